// File: doc/BRIEF.md
# Left-Predictor Lossless Sample Reconstructor

This block turns a stream of already entropy-decoded prediction differences back into 16-bit image samples. Each arriving difference is added, modulo 2^16, to a prediction formed from a sample that was already rebuilt. Inside a row that prediction is the left neighbour of the same component. The first sample of each row is instead predicted from the first sample of the row above. The first sample of the image, and the first sample after each restart boundary, uses a fixed seed value that depends on the point transform.

Between one and three components are interleaved sample by sample, with no subsampling. Every component keeps its own left and row-start predictor state. Samples leave in raster order with their component index. The last sample of the image is flagged, and the block then starts the next image from a clean position. Width, height, component count, point transform and restart interval are static configuration inputs. The output side may stall at any time without loss.

Top module: `ljp_recon_top`

## Requirements
- R1: Inside a row, each sample equals (previous sample of the same component in that row + difference) mod 2^16.
- R2: The difference is a 16-bit two's complement code. The code 16'h8000 stands for the category-16 difference +32768, and because the sum is taken mod 2^16 it gives the same result as -32768.
- R3: For every component, the first pixel of the image is predicted as 2^(15-pt), where pt is the configured point transform (0 to 15).
- R4: On every row after the first, the first-column sample of each component is predicted from the first-column sample of the same component in the previous row.
- R5: Samples are emitted in component order 0 to ncomp-1 within each pixel, with out_comp giving the index. Each component's predictor state is independent of the others.
- R6: The emitted sample is the rebuilt value shifted left by pt and truncated to 16 bits, so its low pt bits are zero. Prediction works on the value before the shift.
- R7: When the restart interval N is non-zero, every pixel whose index from the image start is a multiple of N uses the seed 2^(15-pt) for all of its components. N = 0 disables restarts.
- R8: out_last is high only on sample number width*height*ncomp of an image. The next difference after it starts a new image at row 0, column 0, component 0.
- R9: While out_valid is high and out_ready is low, the output sample, component and last flag hold, and in_ready is low, so no difference is accepted or lost.
- R10: After reset, out_valid is low, in_ready is high, and the first difference is treated as the first sample of an image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | 16 | Pixels per row (1 or more) |
| cfg_height | input | 16 | Rows per image (1 or more) |
| cfg_ncomp | input | 2 | Components per pixel, 1 to 3 |
| cfg_pt | input | 4 | Point transform shift, 0 to 15 |
| cfg_rst_int | input | 16 | Restart interval in pixels, 0 means none |
| in_valid | input | 1 | Difference present |
| in_ready | output | 1 | Difference accepted this cycle when in_valid is high |
| in_diff | input | 16 | Decoded difference, two's complement |
| out_valid | output | 1 | Rebuilt sample present |
| out_ready | input | 1 | Consumer takes the sample |
| out_sample | output | 16 | Rebuilt sample after point transform |
| out_comp | output | 2 | Component index of out_sample |
| out_last | output | 1 | Final sample of the image |

## Verification
The assertions check on every cycle the properties that need no knowledge of the pixel values. These are: the output holds during a stall, the component index stays in range and steps in order, the last flag falls only on the final component, the low pt bits are clear, and the output is empty after reset. The arithmetic itself can only be shown by the bench scenarios, which compare the output against a model built from the requirements. This covers left prediction, row-start prediction from above, seeding at the image start and at restart boundaries, category-16 differences, wraparound, and restarting across back-to-back images.

// File: rtl/ljp_pkg.sv
package ljp_pkg;

    localparam int unsigned SAMPLE_W = 16;
    localparam int unsigned COMP_MAX = 3;
    localparam int unsigned COMP_W   = 2;
    localparam int unsigned PT_W     = 4;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef enum logic [1:0] {
        PRED_SEED  = 2'd0,
        PRED_ABOVE = 2'd1,
        PRED_LEFT  = 2'd2
    } pred_sel_e;

    typedef struct packed {
        logic [COMP_W-1:0] comp;
        logic              first_col;
        logic              seed;
        logic              last_comp;
        logic              last;
    } pos_t;

    function automatic sample_t seed_value(input logic [PT_W-1:0] pt);
        return sample_t'(1) << (SAMPLE_W - 1 - int'(pt));
    endfunction

    function automatic sample_t apply_pt(input sample_t v, input logic [PT_W-1:0] pt);
        return v << pt;
    endfunction

endpackage

// File: rtl/ljp_raster_ctr.sv
module ljp_raster_ctr
    import ljp_pkg::*;
#(
    parameter int unsigned DIM_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 step,
    input  logic [DIM_W-1:0]     cfg_width,
    input  logic [DIM_W-1:0]     cfg_height,
    input  logic [COMP_W-1:0]    cfg_ncomp,
    input  logic [DIM_W-1:0]     cfg_rst_int,
    output pos_t                 pos
);

    logic [COMP_W-1:0] comp_q;
    logic [DIM_W-1:0]  col_q;
    logic [DIM_W-1:0]  row_q;
    logic [DIM_W-1:0]  rcnt_q;

    logic last_comp, last_col, last_row, last_all, rst_wrap;

    always_comb begin
        last_comp = (comp_q == cfg_ncomp - COMP_W'(1));
        last_col  = (col_q == cfg_width - DIM_W'(1));
        last_row  = (row_q == cfg_height - DIM_W'(1));
        last_all  = last_comp && last_col && last_row;
        rst_wrap  = (cfg_rst_int != '0) && (rcnt_q == cfg_rst_int - DIM_W'(1));

        pos.comp      = comp_q;
        pos.first_col = (col_q == '0);
        pos.seed      = ((row_q == '0) && (col_q == '0)) ||
                        ((cfg_rst_int != '0) && (rcnt_q == '0));
        pos.last_comp = last_comp;
        pos.last      = last_all;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            comp_q <= '0;
            col_q  <= '0;
            row_q  <= '0;
            rcnt_q <= '0;
        end else if (step) begin
            if (!last_comp) begin
                comp_q <= comp_q + COMP_W'(1);
            end else begin
                comp_q <= '0;
                if (last_col) begin
                    col_q <= '0;
                    row_q <= last_row ? '0 : row_q + DIM_W'(1);
                end else begin
                    col_q <= col_q + DIM_W'(1);
                end
                rcnt_q <= (last_all || rst_wrap) ? '0 : rcnt_q + DIM_W'(1);
            end
        end
    end

    // R5: components step in order inside a pixel
    p_comp_step_r5: assert property (@(posedge clk) disable iff (rst)
        (step && !last_comp) |=> (comp_q == $past(comp_q) + COMP_W'(1)));

    // R8: after the final sample the position returns to the image origin
    p_image_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (step && last_all) |=> (comp_q == '0 && col_q == '0 && row_q == '0));

endmodule

// File: rtl/ljp_pred_store.sv
module ljp_pred_store
    import ljp_pkg::*;
#(
    parameter int unsigned NCOMP = COMP_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [COMP_W-1:0] comp,
    input  logic              first_col,
    input  sample_t           value,
    output sample_t           left_val,
    output sample_t           above_val
);

    sample_t left_q  [NCOMP];
    sample_t above_q [NCOMP];

    for (genvar g = 0; g < NCOMP; g++) begin : g_comp
        logic hit;
        assign hit = wr_en && (comp == COMP_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                left_q[g]  <= '0;
                above_q[g] <= '0;
            end else if (hit) begin
                left_q[g] <= value;
                if (first_col) begin
                    above_q[g] <= value;
                end
            end
        end
    end

    always_comb begin
        left_val  = '0;
        above_val = '0;
        for (int i = 0; i < NCOMP; i++) begin
            if (comp == COMP_W'(i)) begin
                left_val  = left_q[i];
                above_val = above_q[i];
            end
        end
    end

endmodule

// File: rtl/ljp_recon_top.sv
module ljp_recon_top
    import ljp_pkg::*;
#(
    parameter int unsigned DIM_W = 16,
    parameter int unsigned NCOMP = COMP_MAX
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DIM_W-1:0]    cfg_width,
    input  logic [DIM_W-1:0]    cfg_height,
    input  logic [COMP_W-1:0]   cfg_ncomp,
    input  logic [PT_W-1:0]     cfg_pt,
    input  logic [DIM_W-1:0]    cfg_rst_int,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_diff,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic [COMP_W-1:0]   out_comp,
    output logic                out_last
);

    pos_t      pos;
    pred_sel_e sel;
    sample_t   left_val, above_val, pred, recon;
    logic      step;

    assign in_ready = !out_valid || out_ready;
    assign step     = in_valid && in_ready;

    ljp_raster_ctr #(.DIM_W(DIM_W)) u_ctr (
        .clk         (clk),
        .rst         (rst),
        .step        (step),
        .cfg_width   (cfg_width),
        .cfg_height  (cfg_height),
        .cfg_ncomp   (cfg_ncomp),
        .cfg_rst_int (cfg_rst_int),
        .pos         (pos)
    );

    ljp_pred_store #(.NCOMP(NCOMP)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (step),
        .comp      (pos.comp),
        .first_col (pos.first_col),
        .value     (recon),
        .left_val  (left_val),
        .above_val (above_val)
    );

    always_comb begin
        if (pos.seed)           sel = PRED_SEED;
        else if (pos.first_col) sel = PRED_ABOVE;
        else                    sel = PRED_LEFT;

        unique case (sel)
            PRED_SEED:  pred = seed_value(cfg_pt);
            PRED_ABOVE: pred = above_val;
            default:    pred = left_val;
        endcase
        recon = pred + in_diff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
            out_comp   <= '0;
            out_last   <= 1'b0;
        end else if (step) begin
            out_valid  <= 1'b1;
            out_sample <= apply_pt(recon, cfg_pt);
            out_comp   <= pos.comp;
            out_last   <= pos.last;
        end else if (out_ready) begin
            out_valid  <= 1'b0;
        end
    end

    // R9: a stalled output holds and no input is taken
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sample) &&
                                       $stable(out_comp) && $stable(out_last)));

    // R5: component index within the configured count
    p_comp_range_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_comp < cfg_ncomp));

    // R6: shifted-out bits are clear
    p_pt_low_zero_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_sample & ((SAMPLE_W'(1) << cfg_pt) - SAMPLE_W'(1))) == '0));

    // R8: last flag only on the final component of a pixel
    p_last_comp_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last) |-> (out_comp == cfg_ncomp - COMP_W'(1)));

    // R10: output empty right after reset
    p_reset_empty_r10: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

// File: tb/sim_ljp_recon_top.sv
module sim_ljp_recon_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_width = 16'd1, cfg_height = 16'd1, cfg_rst_int = 16'd0;
    logic [1:0]  cfg_ncomp = 2'd1;
    logic [3:0]  cfg_pt = 4'd0;
    logic        in_valid = 1'b0, out_ready = 1'b1;
    logic [15:0] in_diff = 16'd0;
    logic        in_ready, out_valid, out_last;
    logic [15:0] out_sample;
    logic [1:0]  out_comp;

    int vectors = 0;
    int miscompares = 0;

    logic [15:0] dif [0:511];
    logic [15:0] ex  [0:511];

    always #4 clk = ~clk;

    ljp_recon_top u0 (
        .clk(clk), .rst(rst),
        .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_ncomp(cfg_ncomp),
        .cfg_pt(cfg_pt), .cfg_rst_int(cfg_rst_int),
        .in_valid(in_valid), .in_ready(in_ready), .in_diff(in_diff),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_sample(out_sample), .out_comp(out_comp), .out_last(out_last)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        vectors++;
        if (act !== expv) begin
            miscompares++;
            $display("FAIL %s actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    // fill: 0 small random, 1 all 16'h8000, 2 full-range random
    task automatic run_image(input string tag, input int w, input int h, input int nc,
                             input int pt, input int ri, input int fill, input bit stall);
        int n = w * h * nc;
        logic [15:0] lft [3];
        logic [15:0] abv [3];
        logic [15:0] seed = 16'(16'd1 << (15 - pt));
        int i = 0;
        int k = 0;
        int cyc = 0;
        cfg_width   = 16'(w);
        cfg_height  = 16'(h);
        cfg_ncomp   = 2'(nc);
        cfg_pt      = 4'(pt);
        cfg_rst_int = 16'(ri);
        for (int c = 0; c < 3; c++) begin lft[c] = 16'd0; abv[c] = 16'd0; end
        for (int idx = 0; idx < n; idx++) begin
            int pix = idx / nc;
            int c = idx % nc;
            int col = pix % w;
            logic [15:0] pred, rec;
            if (fill == 1)      dif[idx] = 16'h8000;
            else if (fill == 0) dif[idx] = 16'(($urandom % 64) - 32);
            else                dif[idx] = 16'($urandom);
            if (pix == 0 || (ri != 0 && (pix % ri) == 0)) pred = seed;
            else if (col == 0)                             pred = abv[c];
            else                                           pred = lft[c];
            rec = pred + dif[idx];
            lft[c] = rec;
            if (col == 0) abv[c] = rec;
            ex[idx] = 16'(rec << pt);
        end
        while (k < n && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            out_ready = stall ? (($urandom % 3) != 0) : 1'b1;
            if (i < n) begin
                in_valid = stall ? 1'($urandom % 2) : 1'b1;
                in_diff  = dif[i];
            end else begin
                in_valid = 1'b0;
            end
            #1;
            if (stall && out_valid && !out_ready)
                chk({tag, " R9 in_ready during stall"}, 32'(in_ready), 32'd0);
            if (out_valid && out_ready) begin
                chk({tag, " sample"}, 32'(out_sample), 32'(ex[k]));
                chk("R5 component index", 32'(out_comp), 32'(k % nc));
                chk("R8 last flag", 32'(out_last), 32'(k == n - 1));
                k++;
            end
            if (in_valid && in_ready) i++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        out_ready = 1'b1;
        chk({tag, " all samples out"}, 32'(k), 32'(n));
    endtask

    task automatic t_reset();
        #1;
        chk("R10 out_valid after reset", 32'(out_valid), 32'd0);
        chk("R10 in_ready after reset", 32'(in_ready), 32'd1);
    endtask

    task automatic t_basic();
        run_image("R1 R3 R4 single comp", 4, 3, 1, 0, 0, 0, 1'b0);
        run_image("R1 wrap full range", 5, 2, 1, 0, 0, 2, 1'b0);
    endtask

    task automatic t_interleave();
        run_image("R5 three comps", 3, 2, 3, 0, 0, 0, 1'b0);
        run_image("R5 two comps", 4, 2, 2, 0, 0, 2, 1'b0);
    endtask

    task automatic t_big_diff();
        run_image("R2 code 8000", 3, 2, 2, 0, 0, 1, 1'b0);
        run_image("R2 code 8000 pt2", 2, 2, 1, 2, 0, 1, 1'b0);
    endtask

    task automatic t_ptshift();
        run_image("R6 R3 pt3", 4, 2, 2, 3, 0, 0, 1'b0);
        run_image("R6 R3 pt15", 3, 2, 1, 15, 0, 0, 1'b0);
    endtask

    task automatic t_restart();
        run_image("R7 interval 2", 3, 3, 2, 0, 2, 0, 1'b0);
        run_image("R7 interval 4", 3, 3, 3, 1, 4, 0, 1'b0);
    endtask

    task automatic t_stall();
        run_image("R9 stalls", 5, 4, 3, 0, 0, 2, 1'b1);
        run_image("R9 stalls restart", 4, 3, 2, 2, 3, 0, 1'b1);
    endtask

    task automatic t_back_to_back();
        run_image("R8 image a", 2, 2, 3, 0, 0, 0, 1'b0);
        run_image("R8 image b", 3, 1, 3, 0, 0, 0, 1'b0);
        run_image("R8 image c", 1, 3, 1, 0, 0, 2, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_interleave();
        t_big_diff();
        t_ptshift();
        t_restart();
        t_stall();
        t_back_to_back();
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual running expected done");
        summary();
        $finish;
    end

endmodule